// File: doc/BRIEF.md
# Comparator Edge-Detect Controller

This block is the digital side of an external analog comparator. The comparator's raw output arrives with no timing relation to the system clock. The block can invert it, then passes it through a flop synchronizer. It watches the resulting level for a selected kind of transition. A qualifying transition sets a sticky edge flag, and reading the interrupt status register clears that flag. The flag drives an interrupt line through a mask bit. A fault line can be driven from either the flag or the live synchronized level.

Software reaches the block over a simple 32-bit register bus. A write takes effect on the clock edge that samples it. A read returns its data on `bus_rdata` one clock after `bus_rd` is sampled. The settings for the comparator's input multiplexer, bias current and hysteresis leave the block as plain outputs, unchanged. A keyed write lock protects the configuration registers. Writes that the lock blocks are recorded in a violation bit.

Top module: `cmp_edge_ctrl`

## Requirements
- R1: After reset, every readable register reads 0 except the version word, and `irq`, `fault`, `mux_minus`, `mux_plus`, `cmp_enable`, `bias_fast` and `hyst_sel` are 0.
- R2: The mode register (offset 0x04) uses these fields: minus select [2:0], plus select [6:4], comparator enable bit 8, edge type [10:9], invert bit 12, fault source bit 13 and fault enable bit 14. It reads back as written, and it drives `mux_minus`, `mux_plus` and `cmp_enable` directly.
- R3: The comparator input passes through a two-flop synchronizer. Bit 1 of the status register (offset 0x30) reads the synchronized, processed level.
- R4: Edge type 0 flags only rising edges and type 1 flags only falling edges. Types 2 and 3 flag both. A flagged edge sets status bit 0.
- R5: When the invert bit is set, the raw input is complemented before it is synchronized and checked for edges.
- R6: While the comparator enable bit is 0, no edge sets the flag, but the level in status bit 1 still tracks the input.
- R7: Reading the status register returns the flag and then clears it. If an edge is detected in the same cycle as that read, the flag stays set.
- R8: Writing 1 to bit 0 at offset 0x24 sets the interrupt mask, and writing 1 to bit 0 at offset 0x28 clears it. Offset 0x2C bit 0 reads the mask. `irq` is high exactly when the flag and the mask are both set.
- R9: With fault enable at 0, `fault` is 0. With fault enable at 1, `fault` follows the edge flag when the fault source bit is 0, and the synchronized level when it is 1.
- R10: The analog control register (offset 0x94) holds a bias-current bit 0 and a hysteresis field [2:1]. These drive `bias_fast` and `hyst_sel` and read back.
- R11: The lock bit (offset 0xE4 bit 0) changes only on a write whose bits [31:8] equal 0x414343. Writes with any other key are ignored, and bits [31:8] always read as 0.
- R12: While the lock bit is set, writes to the mode and analog control registers are discarded and set the violation bit (offset 0xE8 bit 0). Reading offset 0xE8 clears the violation bit.
- R13: Writing 1 to bit 0 of the control register (offset 0x00) returns every register, the mask, the flag, the lock bit and the violation bit to their reset values.
- R14: Offset 0xFC reads the constant version word given by parameter `HW_VERSION`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read strobe |
| cmp_raw | input | 1 | Asynchronous comparator output |
| irq | output | 1 | Edge interrupt |
| fault | output | 1 | Fault indication |
| mux_minus | output | 3 | Minus input selection to the analog mux |
| mux_plus | output | 3 | Plus input selection to the analog mux |
| cmp_enable | output | 1 | Comparator enable |
| bias_fast | output | 1 | High-speed bias current selection |
| hyst_sel | output | 2 | Hysteresis selection |

## Verification
An edge-type field that is decoded wrongly, or an inverted synchronizer stage, shows up at the status register on the first read after an input transition. That read comes three clocks after the input changes. If the clear-on-read priority is wrong, a transition that lands on a status read is lost. The bench aligns a transition with a status read and then checks for the flag on the next read. A lock or key fault shows at once: the next read of the mode or analog register returns the wrong value, and so do the exported pins.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MODE   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_IEN    = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_IDIS   = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_IMSK   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_ISTAT  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_ANA    = 8'h94;
  localparam logic [ADDR_W-1:0] OFF_WPCFG  = 8'hE4;
  localparam logic [ADDR_W-1:0] OFF_WPSTAT = 8'hE8;
  localparam logic [ADDR_W-1:0] OFF_VER    = 8'hFC;

  localparam logic [23:0] LOCK_KEY = 24'h414343;

  typedef enum logic [1:0] {
    EDGE_RISE    = 2'd0,
    EDGE_FALL    = 2'd1,
    EDGE_BOTH    = 2'd2,
    EDGE_BOTH_HI = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic      fault_en;
    logic      fault_lvl;
    logic      invert;
    edge_sel_e edge_sel;
    logic      enable;
    logic [2:0] sel_plus;
    logic [2:0] sel_minus;
  } mode_t;

  function automatic mode_t word_to_mode(input logic [DATA_W-1:0] w);
    mode_t m;
    m.sel_minus = w[2:0];
    m.sel_plus  = w[6:4];
    m.enable    = w[8];
    m.edge_sel  = edge_sel_e'(w[10:9]);
    m.invert    = w[12];
    m.fault_lvl = w[13];
    m.fault_en  = w[14];
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] mode_to_word(input mode_t m);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[2:0]   = m.sel_minus;
    w[6:4]   = m.sel_plus;
    w[8]     = m.enable;
    w[10:9]  = m.edge_sel;
    w[12]    = m.invert;
    w[13]    = m.fault_lvl;
    w[14]    = m.fault_en;
    return w;
  endfunction
endpackage

// File: rtl/cmpc_sync_edge.sv
module cmpc_sync_edge
  import cmpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      raw_in,
  input  logic      invert,
  input  logic      enable,
  input  edge_sel_e edge_sel,
  output logic      level,
  output logic      edge_pulse
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain;
  logic          prev;
  logic          rise, fall;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], raw_in ^ invert};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain[0] <= raw_in ^ invert;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[LAST];
  end

  assign level = chain[LAST];
  assign rise  = chain[LAST] & ~prev;
  assign fall  = ~chain[LAST] & prev;

  always_comb begin
    unique case (edge_sel)
      EDGE_RISE: edge_pulse = enable & rise;
      EDGE_FALL: edge_pulse = enable & fall;
      default:   edge_pulse = enable & (rise | fall);
    endcase
  end

  // R3
  level_follows_chain_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (level == $past(chain[LAST-1 < 0 ? 0 : (LAST > 0 ? LAST-1 : 0)]) || SYNC_STAGES == 1))
    else $error("synchronizer stage order broken");
endmodule

// File: rtl/cmpc_regs.sv
module cmpc_regs
  import cmpc_pkg::*;
#(
  parameter logic [DATA_W-1:0] HW_VERSION = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              edge_pulse,
  input  logic              level,
  output mode_t             mode,
  output logic              irq_mask,
  output logic              edge_flag,
  output logic              bias_fast,
  output logic [1:0]        hyst_sel
);
  logic lock_q, viol_q;
  logic soft_rst;
  logic wr_mode, wr_ana, blocked, key_ok;
  logic rd_stat, rd_wpstat;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wdata;

  assign soft_rst  = bus_wr && bus_addr == OFF_CTRL && bus_wdata[0];
  assign wr_mode   = bus_wr && bus_addr == OFF_MODE;
  assign wr_ana    = bus_wr && bus_addr == OFF_ANA;
  assign blocked   = lock_q && (wr_mode || wr_ana);
  assign key_ok    = bus_wdata[31:8] == LOCK_KEY;
  assign rd_stat   = bus_rd && bus_addr == OFF_ISTAT;
  assign rd_wpstat = bus_rd && bus_addr == OFF_WPSTAT;
  assign unused_wdata = ^{bus_wdata[31:15], bus_wdata[11], bus_wdata[7], bus_wdata[3]};

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      mode      <= '0;
      bias_fast <= 1'b0;
      hyst_sel  <= 2'b00;
      irq_mask  <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      if (wr_mode && !lock_q) mode <= word_to_mode(bus_wdata);
      if (wr_ana && !lock_q) begin
        bias_fast <= bus_wdata[0];
        hyst_sel  <= bus_wdata[2:1];
      end
      if (bus_wr && bus_addr == OFF_IEN && bus_wdata[0])  irq_mask <= 1'b1;
      else if (bus_wr && bus_addr == OFF_IDIS && bus_wdata[0]) irq_mask <= 1'b0;
      if (bus_wr && bus_addr == OFF_WPCFG && key_ok) lock_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst)  edge_flag <= 1'b0;
    else if (edge_pulse)  edge_flag <= 1'b1;
    else if (rd_stat)     edge_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst)  viol_q <= 1'b0;
    else if (blocked)     viol_q <= 1'b1;
    else if (rd_wpstat)   viol_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFF_MODE:   rd_mux = mode_to_word(mode);
      OFF_IMSK:   rd_mux[0] = irq_mask;
      OFF_ISTAT:  rd_mux[1:0] = {level, edge_flag};
      OFF_ANA:    rd_mux[2:0] = {hyst_sel, bias_fast};
      OFF_WPCFG:  rd_mux[0] = lock_q;
      OFF_WPSTAT: rd_mux[0] = viol_q;
      OFF_VER:    rd_mux = HW_VERSION;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R7
  flag_clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !edge_pulse) |=> !edge_flag)
    else $error("status read did not clear flag");

  // R4
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_pulse && !soft_rst) |=> edge_flag)
    else $error("detected edge lost");

  // R12
  locked_write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q && wr_mode) |=> ($stable(mode) && viol_q))
    else $error("locked mode write took effect");

  // R11
  bad_key_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_WPCFG && !key_ok) |=> $stable(lock_q))
    else $error("lock changed without key");

  // R13
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (mode == '0 && !lock_q && !irq_mask && !edge_flag && !viol_q))
    else $error("software reset incomplete");
endmodule

// File: rtl/cmp_edge_ctrl.sv
module cmp_edge_ctrl
  import cmpc_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [31:0]       HW_VERSION  = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        cmp_raw,
  output logic        irq,
  output logic        fault,
  output logic [2:0]  mux_minus,
  output logic [2:0]  mux_plus,
  output logic        cmp_enable,
  output logic        bias_fast,
  output logic [1:0]  hyst_sel
);
  mode_t mode;
  logic  level, edge_pulse, irq_mask, edge_flag;

  cmpc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .raw_in     (cmp_raw),
    .invert     (mode.invert),
    .enable     (mode.enable),
    .edge_sel   (mode.edge_sel),
    .level      (level),
    .edge_pulse (edge_pulse)
  );

  cmpc_regs #(.HW_VERSION(HW_VERSION)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .edge_pulse (edge_pulse),
    .level      (level),
    .mode       (mode),
    .irq_mask   (irq_mask),
    .edge_flag  (edge_flag),
    .bias_fast  (bias_fast),
    .hyst_sel   (hyst_sel)
  );

  assign irq        = edge_flag & irq_mask;
  assign fault      = mode.fault_en & (mode.fault_lvl ? level : edge_flag);
  assign mux_minus  = mode.sel_minus;
  assign mux_plus   = mode.sel_plus;
  assign cmp_enable = mode.enable;

  // R6
  no_edge_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode.enable && !edge_flag && !(bus_wr && bus_addr != OFF_MODE)) |=> (!edge_flag || $past(bus_wr)))
    else $error("edge flagged while comparator disabled");
endmodule

// File: tb/cmp_edge_ctrl_tb.sv
module cmp_edge_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmp_raw = 1'b0;
  logic        irq, fault, cmp_enable, bias_fast;
  logic [2:0]  mux_minus, mux_plus;
  logic [1:0]  hyst_sel;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  logic [31:0] msk_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;

  always #4 clk = ~clk;

  cmp_edge_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_raw(cmp_raw), .irq(irq),
    .fault(fault), .mux_minus(mux_minus), .mux_plus(mux_plus), .cmp_enable(cmp_enable),
    .bias_fast(bias_fast), .hyst_sel(hyst_sel)
  );

  always @(posedge clk) pend <= bus_rd;

  // monitor: compares each returned read with the queued expectation
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [31:0] e, m;
      string t;
      e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
      if (m != 0) begin
        tests++;
        if ((bus_rdata & m) != (e & m)) begin
          fails++;
          $display("FAIL %s: read got %h expected %h", t, bus_rdata & m, e & m);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input logic [31:0] m, input string t);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    tests++;
    if (act != e) begin
      fails++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state, R14 version
    chk({irq, fault, cmp_enable, bias_fast}, 0, "R1 outputs");
    chk({mux_minus, mux_plus, hyst_sel}, 0, "R1 selects");
    rd(8'h04, 0, '1, "R1 mode");
    rd(8'h30, 0, '1, "R1 status");
    rd(8'h2C, 0, '1, "R1 mask");
    rd(8'h94, 0, '1, "R1 analog");
    rd(8'hE4, 0, '1, "R1 lock");
    rd(8'hE8, 0, '1, "R1 violation");
    rd(8'hFC, 32'h0000_0100, '1, "R14 version");

    // R2 mode fields: minus 5, plus 3, enable, rising, fault enable
    wr(8'h04, 32'h0000_4135);
    rd(8'h04, 32'h0000_4135, '1, "R2 readback");
    chk({mux_minus, mux_plus, cmp_enable}, {3'd5, 3'd3, 1'b1}, "R2 pins");

    // R3/R4 rising edge, R9 fault from flag
    cmp_raw = 1'b1; idle(5);
    chk(fault, 1, "R9 fault follows flag");
    rd(8'h30, 3, '1, "R4 rising flagged R3 level");
    chk(fault, 0, "R9 fault after clear");
    rd(8'h30, 2, '1, "R7 cleared on read");

    // R8 mask and irq
    wr(8'h24, 1);
    rd(8'h2C, 1, '1, "R8 mask set");
    cmp_raw = 1'b0; idle(5);
    rd(8'h30, 0, '1, "R4 falling ignored in rising mode");
    chk(irq, 0, "R8 irq idle");
    cmp_raw = 1'b1; idle(5);
    chk(irq, 1, "R8 irq asserted");
    wr(8'h28, 1);
    chk(irq, 0, "R8 irq masked");
    rd(8'h30, 3, '1, "R8 flag still held");

    // R4 falling mode
    wr(8'h04, 32'h0000_4335);
    cmp_raw = 1'b0; idle(5);
    rd(8'h30, 1, '1, "R4 falling flagged");
    cmp_raw = 1'b1; idle(5);
    rd(8'h30, 2, '1, "R4 rising ignored in falling mode");

    // R4 any edge
    wr(8'h04, 32'h0000_4535);
    cmp_raw = 1'b0; idle(5);
    rd(8'h30, 1, '1, "R4 any falling");
    cmp_raw = 1'b1; idle(5);
    rd(8'h30, 3, '1, "R4 any rising");

    // R5 invert, rising mode: raw 1 -> processed 0
    wr(8'h04, 32'h0000_5135); idle(5);
    rd(8'h30, 0, '1, "R5 inverted level low");
    cmp_raw = 1'b0; idle(5);
    rd(8'h30, 3, '1, "R5 inverted rise");

    // R6 disabled: level tracks, no flag
    wr(8'h04, 32'h0000_5035);
    chk(cmp_enable, 0, "R6 enable pin");
    cmp_raw = 1'b1; idle(5);
    cmp_raw = 1'b0; idle(5);
    rd(8'h30, 2, '1, "R6 no flag while disabled");

    // R9 fault from level
    wr(8'h04, 32'h0000_7135); idle(1);
    chk(fault, 1, "R9 fault level high");
    cmp_raw = 1'b1; idle(5);
    chk(fault, 0, "R9 fault level low");
    wr(8'h04, 32'h0000_3135);
    cmp_raw = 1'b0; idle(5);
    chk(fault, 0, "R9 fault disabled");

    // R7 edge coinciding with a status read
    wr(8'h04, 32'h0000_4135); idle(5);
    rd(8'h30, 0, 0, "clear");
    idle(2);
    cmp_raw = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(8'h30, 2, '1, "R7 read during edge");
    rd(8'h30, 3, '1, "R7 edge kept");

    // R10 analog control
    wr(8'h94, 7);
    chk({bias_fast, hyst_sel}, 3'b111, "R10 pins");
    rd(8'h94, 7, '1, "R10 readback");

    // R11 key check
    wr(8'hE4, 32'h1234_5601);
    rd(8'hE4, 0, '1, "R11 wrong key ignored");
    wr(8'hE4, 32'h4143_4301);
    rd(8'hE4, 1, '1, "R11 key accepted, key reads 0");

    // R12 locked writes
    wr(8'h04, 0);
    rd(8'h04, 32'h0000_4135, '1, "R12 mode kept");
    wr(8'h94, 0);
    chk(hyst_sel, 3, "R12 analog kept");
    rd(8'hE8, 1, '1, "R12 violation set");
    rd(8'hE8, 0, '1, "R12 violation cleared");

    // R13 software reset
    wr(8'h24, 1);
    wr(8'h00, 1);
    rd(8'hE4, 0, '1, "R13 lock cleared");
    rd(8'h04, 0, '1, "R13 mode cleared");
    rd(8'h94, 0, '1, "R13 analog cleared");
    rd(8'h2C, 0, '1, "R13 mask cleared");
    chk({mux_minus, mux_plus, cmp_enable, irq}, 0, "R13 pins");

    idle(4);
    finish_run();
  end
endmodule